// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a virtual address into a physical address by fetching two table entries from memory, one after the other. A translation request carries the virtual address. On acceptance the walker latches that address and the current root pointer (the physical address of the top-level directory, supplied by a control register outside the block). It reads the directory entry selected by the upper index field of the virtual address. If that entry is valid, it reads the leaf-table entry selected by the middle index field. The physical address is the leaf entry's frame number joined to the untouched page offset.

Each entry is one word. Its upper bits hold a page-aligned frame number and its low offset-width bits hold flags, of which only bit 0 (valid) is interpreted. A cleared valid bit at either level ends the walk early with a fault. The fault output names the level that failed and carries no address.

Memory is reached through a single read port: a one-cycle request strobe with an address, answered by a data strobe any number of cycles later. Only one walk is in flight at a time. A new request is taken only while the walker is idle.

Top module: `ptw_walker`

## Requirements
- R1: A successful walk returns rsp_paddr equal to the leaf entry's frame field (entry bits PA_W-1:OFF_W) concatenated with the low OFF_W bits of the virtual address, with rsp_fault low.
- R2: The first read goes to the root pointer with its low OFF_W bits forced to zero, plus 4 times the directory index (the top DIR_IDX_W bits of the virtual address).
- R3: The second read goes to the directory entry's frame field followed by OFF_W zero bits, plus 4 times the table index (the TBL_IDX_W virtual address bits just above the offset).
- R4: When the directory entry has bit 0 clear, the walk issues no second read and responds with rsp_fault high and rsp_fault_lvl 0.
- R5: When the leaf entry has bit 0 clear, the walk responds with rsp_fault high, rsp_fault_lvl 1 and rsp_paddr zero.
- R6: Entry bits 1 to OFF_W-1 (the flags other than valid) have no effect on the read addresses or on the returned address.
- R7: req_ready is high only while idle. Each accepted request yields exactly one response, a single-cycle rsp_valid pulse, and req_ready is high again the cycle after it.
- R8: The root pointer is sampled when the request is accepted. Changing it during a walk does not affect that walk.
- R9: Read data may return any number of cycles (one or more) after the request. mem_rd_req is a single-cycle pulse, with at most one read outstanding.
- R10: While reset is applied, req_ready is high and mem_rd_req and rsp_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_root | input | PA_W | Physical address of the top-level directory |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | DIR_IDX_W+TBL_IDX_W+OFF_W | Virtual address to translate |
| mem_rd_req | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | PA_W | Byte address of the entry to read |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | PA_W | Entry word returned by memory |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | PA_W | Translated physical address (zero on fault) |
| rsp_fault | output | 1 | Translation failed |
| rsp_fault_lvl | output | 1 | Failing level: 0 directory, 1 leaf table |

## Verification
The bench builds the walker with 3-bit directory and table indices, a 6-bit offset and 12-bit physical addresses. That reduces the virtual space to 4096 addresses, so every one of them is translated. The sweep covers every directory slot, every table slot and every offset, including a directory slot and several leaf slots left invalid, with flag bits set throughout. The read latency rotates with the address and one run uses a long delay. Further walks move the root pointer just after acceptance, point it at an empty directory, and give it non-zero low bits.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_RD,
    S_DIR_WT,
    S_TBL_RD,
    S_TBL_WT,
    S_RESP
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_level_e;

  localparam int unsigned ENTRY_BYTES_LOG2 = 2;
  localparam int unsigned VALID_POS        = 0;
endpackage

// File: rtl/ptw_index_split.sv
module ptw_index_split #(
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned OFF_W     = 12
) (
  input  logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] vaddr,
  output logic [DIR_IDX_W-1:0]                 dir_idx,
  output logic [TBL_IDX_W-1:0]                 tbl_idx,
  output logic [OFF_W-1:0]                     page_off
);
  localparam int unsigned VA_W    = DIR_IDX_W + TBL_IDX_W + OFF_W;
  localparam int unsigned TBL_LSB = OFF_W;
  localparam int unsigned DIR_LSB = OFF_W + TBL_IDX_W;

  assign page_off = vaddr[OFF_W-1:0];
  assign tbl_idx  = vaddr[DIR_LSB-1:TBL_LSB];
  assign dir_idx  = vaddr[VA_W-1:DIR_LSB];
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input  logic [PA_W-1:0]       entry,
  output logic                  valid,
  output logic [PA_W-OFF_W-1:0] frame
);
  assign valid = entry[VALID_POS];
  assign frame = entry[PA_W-1:OFF_W];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W      = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10
) (
  input  walk_level_e           level,
  input  logic [PA_W-OFF_W-1:0] root_frame,
  input  logic [PA_W-OFF_W-1:0] tbl_frame,
  input  logic [DIR_IDX_W-1:0]  dir_idx,
  input  logic [TBL_IDX_W-1:0]  tbl_idx,
  output logic [PA_W-1:0]       rd_addr
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic [FRAME_W-1:0] base_frame;
  logic [PA_W-1:0]    idx_off;

  generate
    if (OFF_W >= DIR_IDX_W + ENTRY_BYTES_LOG2 && OFF_W >= TBL_IDX_W + ENTRY_BYTES_LOG2) begin : g_in_page
      // The scaled index fits inside the page offset, so the add reduces to a concatenation.
      logic [OFF_W-1:0] low_bits;
      always_comb begin
        low_bits = '0;
        if (level == LVL_TBL) low_bits[TBL_IDX_W+ENTRY_BYTES_LOG2-1:ENTRY_BYTES_LOG2] = tbl_idx;
        else                  low_bits[DIR_IDX_W+ENTRY_BYTES_LOG2-1:ENTRY_BYTES_LOG2] = dir_idx;
      end
      assign idx_off = {{FRAME_W{1'b0}}, low_bits};
    end else begin : g_full_add
      always_comb begin
        idx_off = '0;
        if (level == LVL_TBL) idx_off[TBL_IDX_W+ENTRY_BYTES_LOG2-1:ENTRY_BYTES_LOG2] = tbl_idx;
        else                  idx_off[DIR_IDX_W+ENTRY_BYTES_LOG2-1:ENTRY_BYTES_LOG2] = dir_idx;
      end
    end
  endgenerate

  assign base_frame = (level == LVL_TBL) ? tbl_frame : root_frame;
  assign rd_addr    = {base_frame, {OFF_W{1'b0}}} + idx_off;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int unsigned PA_W      = 32,
  parameter int unsigned DIR_IDX_W = 10,
  parameter int unsigned TBL_IDX_W = 10,
  parameter int unsigned OFF_W     = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [PA_W-1:0]                      dir_root,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [DIR_IDX_W+TBL_IDX_W+OFF_W-1:0] req_vaddr,
  output logic                                 mem_rd_req,
  output logic [PA_W-1:0]                      mem_rd_addr,
  input  logic                                 mem_rd_valid,
  input  logic [PA_W-1:0]                      mem_rd_data,
  output logic                                 rsp_valid,
  output logic [PA_W-1:0]                      rsp_paddr,
  output logic                                 rsp_fault,
  output logic                                 rsp_fault_lvl
);
  localparam int unsigned VA_W    = DIR_IDX_W + TBL_IDX_W + OFF_W;
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rsync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // State and captured request.
  walk_state_e        st_q, st_d;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] root_q;
  logic [FRAME_W-1:0] tframe_q;
  logic [PA_W-1:0]    paddr_q, paddr_d;
  logic               fault_q, fault_d;
  walk_level_e        flvl_q, flvl_d;
  logic               cap_en, tf_en, res_en;

  logic [DIR_IDX_W-1:0] dir_idx;
  logic [TBL_IDX_W-1:0] tbl_idx;
  logic [OFF_W-1:0]     page_off;
  logic                 ent_valid;
  logic [FRAME_W-1:0]   ent_frame;
  walk_level_e          rd_level;

  ptw_index_split #(
    .DIR_IDX_W (DIR_IDX_W),
    .TBL_IDX_W (TBL_IDX_W),
    .OFF_W     (OFF_W)
  ) i_split (
    .vaddr    (va_q),
    .dir_idx  (dir_idx),
    .tbl_idx  (tbl_idx),
    .page_off (page_off)
  );

  ptw_entry_decode #(
    .PA_W  (PA_W),
    .OFF_W (OFF_W)
  ) i_decode (
    .entry (mem_rd_data),
    .valid (ent_valid),
    .frame (ent_frame)
  );

  assign rd_level = (st_q == S_TBL_RD) ? LVL_TBL : LVL_DIR;

  ptw_addr_gen #(
    .PA_W      (PA_W),
    .OFF_W     (OFF_W),
    .DIR_IDX_W (DIR_IDX_W),
    .TBL_IDX_W (TBL_IDX_W)
  ) i_addr (
    .level      (rd_level),
    .root_frame (root_q),
    .tbl_frame  (tframe_q),
    .dir_idx    (dir_idx),
    .tbl_idx    (tbl_idx),
    .rd_addr    (mem_rd_addr)
  );

  // Next-state logic.
  always_comb begin
    st_d    = st_q;
    cap_en  = 1'b0;
    tf_en   = 1'b0;
    res_en  = 1'b0;
    paddr_d = '0;
    fault_d = 1'b0;
    flvl_d  = LVL_DIR;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          cap_en = 1'b1;
          st_d   = S_DIR_RD;
        end
      end
      S_DIR_RD: st_d = S_DIR_WT;
      S_DIR_WT: begin
        if (mem_rd_valid) begin
          if (ent_valid) begin
            tf_en = 1'b1;
            st_d  = S_TBL_RD;
          end else begin
            res_en  = 1'b1;
            fault_d = 1'b1;
            flvl_d  = LVL_DIR;
            st_d    = S_RESP;
          end
        end
      end
      S_TBL_RD: st_d = S_TBL_WT;
      S_TBL_WT: begin
        if (mem_rd_valid) begin
          res_en = 1'b1;
          st_d   = S_RESP;
          if (ent_valid) begin
            paddr_d = {ent_frame, page_off};
          end else begin
            fault_d = 1'b1;
            flvl_d  = LVL_TBL;
          end
        end
      end
      S_RESP:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q   <= '0;
      root_q <= '0;
    end else if (cap_en) begin
      va_q   <= req_vaddr;
      root_q <= dir_root[PA_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    tframe_q <= '0;
    else if (tf_en) tframe_q <= ent_frame;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      flvl_q  <= LVL_DIR;
    end else if (res_en) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
      flvl_q  <= flvl_d;
    end
  end

  // Outputs decoded from state.
  assign req_ready     = (st_q == S_IDLE);
  assign mem_rd_req    = (st_q == S_DIR_RD) || (st_q == S_TBL_RD);
  assign rsp_valid     = (st_q == S_RESP);
  assign rsp_paddr     = paddr_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = flvl_q;

  // Checks.
  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req |=> !mem_rd_req)
    else $error("read request longer than one cycle");

  p_accept_starts_walk_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> (!req_ready && mem_rd_req))
    else $error("accepted request did not start a directory read");

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |=> (!rsp_valid && req_ready))
    else $error("response not a single pulse followed by idle");

  p_busy_no_ready_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req |-> !req_ready)
    else $error("ready raised during a walk");

  p_fault_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0))
    else $error("fault response carries an address");

  p_dir_fault_skip_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == S_DIR_WT && mem_rd_valid && !ent_valid) |=>
      (rsp_valid && rsp_fault && rsp_fault_lvl == LVL_DIR && !mem_rd_req))
    else $error("invalid directory entry did not end the walk");

  p_rd_aligned_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_rd_req |-> (mem_rd_addr[ENTRY_BYTES_LOG2-1:0] == '0))
    else $error("entry read not word aligned");
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  localparam int unsigned PA_W  = 12;
  localparam int unsigned DIW   = 3;
  localparam int unsigned TIW   = 3;
  localparam int unsigned OFF_W = 6;
  localparam int unsigned VA_W  = DIW + TIW + OFF_W;
  localparam int unsigned WORDS = 1 << (PA_W - 2);

  logic            clk = 1'b0;
  logic            rst_n;
  logic [PA_W-1:0] dir_root;
  logic            req_valid;
  logic            req_ready;
  logic [VA_W-1:0] req_vaddr;
  logic            mem_rd_req;
  logic [PA_W-1:0] mem_rd_addr;
  logic            mem_rd_valid;
  logic [PA_W-1:0] mem_rd_data;
  logic            rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic            rsp_fault;
  logic            rsp_fault_lvl;

  always #10 clk = ~clk;

  ptw_walker #(
    .PA_W      (PA_W),
    .DIR_IDX_W (DIW),
    .TBL_IDX_W (TIW),
    .OFF_W     (OFF_W)
  ) i_ptw_walker (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_root      (dir_root),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .mem_rd_req    (mem_rd_req),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_data   (mem_rd_data),
    .rsp_valid     (rsp_valid),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_fault_lvl (rsp_fault_lvl)
  );

  logic [PA_W-1:0] mem [WORDS];
  int              lat;
  int              rd_cnt;
  logic [PA_W-1:0] rd_log [2];
  int              n_chk = 0;
  int              n_bad = 0;
  bit              done  = 1'b0;

  localparam logic [PA_W-1:0] ROOT_A = 12'h040;
  localparam logic [PA_W-1:0] ROOT_E = 12'hA00;

  // Memory responder: answers lat+1 cycles after each request.
  initial begin
    mem_rd_valid = 1'b0;
    mem_rd_data  = '0;
    forever begin
      @(negedge clk);
      mem_rd_valid = 1'b0;
      if (mem_rd_req) begin
        logic [PA_W-1:0] a;
        a = mem_rd_addr;
        if (rd_cnt < 2) rd_log[rd_cnt] = a;
        rd_cnt++;
        repeat (lat + 1) @(negedge clk);
        mem_rd_valid = 1'b1;
        mem_rd_data  = mem[a[PA_W-1:2]];
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PA_W-1:0] act, input logic [PA_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic walk(input logic [VA_W-1:0] va, input logic [PA_W-1:0] root, input bit move_root);
    logic [DIW-1:0]   d;
    logic [TIW-1:0]   t;
    logic [PA_W-1:0]  da, ta, de, te, exp_pa;
    bit               exp_f, exp_l;
    int               exp_rd;
    bit               got;
    logic [PA_W-1:0]  rb;
    d  = va[VA_W-1:TIW+OFF_W];
    t  = va[TIW+OFF_W-1:OFF_W];
    da = {root[PA_W-1:OFF_W], {OFF_W{1'b0}}} + PA_W'(4 * d);
    de = mem[da[PA_W-1:2]];
    ta = {de[PA_W-1:OFF_W], {OFF_W{1'b0}}} + PA_W'(4 * t);
    te = mem[ta[PA_W-1:2]];
    if (!de[0]) begin
      exp_f = 1'b1; exp_l = 1'b0; exp_pa = '0; exp_rd = 1;
    end else if (!te[0]) begin
      exp_f = 1'b1; exp_l = 1'b1; exp_pa = '0; exp_rd = 2;
    end else begin
      exp_f = 1'b0; exp_l = 1'b0; exp_pa = {te[PA_W-1:OFF_W], va[OFF_W-1:0]}; exp_rd = 2;
    end
    rb = dir_root;
    @(negedge clk);
    rd_cnt    = 0;
    dir_root  = root;
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    req_vaddr = '0;
    if (move_root) dir_root = ROOT_E;
    got = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (rsp_valid) begin got = 1'b1; break; end
      if (req_ready) check(1'b0, "R7", "ready during walk", PA_W'(1), '0);
      @(negedge clk);
    end
    check(got, "R9", "response arrived", PA_W'(got), PA_W'(1));
    if (got) begin
      check(rsp_fault == exp_f, exp_f ? (exp_l ? "R5" : "R4") : "R1", "fault flag", PA_W'(rsp_fault), PA_W'(exp_f));
      if (exp_f) check(rsp_fault_lvl == exp_l, exp_l ? "R5" : "R4", "fault level", PA_W'(rsp_fault_lvl), PA_W'(exp_l));
      check(rsp_paddr == exp_pa, exp_f ? "R5" : "R1", "physical address", rsp_paddr, exp_pa);
      check(rd_cnt == exp_rd, "R4", "read count", PA_W'(rd_cnt), PA_W'(exp_rd));
      check(rd_log[0] == da, move_root ? "R8" : "R2", "directory read addr", rd_log[0], da);
      if (exp_rd == 2) check(rd_log[1] == ta, "R3", "table read addr", rd_log[1], ta);
      @(negedge clk);
      check(!rsp_valid && req_ready, "R7", "single pulse then idle",
            PA_W'({rsp_valid, req_ready}), PA_W'(1));
    end
    dir_root = rb;
  endtask

  // Watchdog.
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_vaddr = '0;
    dir_root  = ROOT_A;
    lat       = 0;
    rd_cnt    = 0;
    for (int w = 0; w < int'(WORDS); w++) mem[w] = '0;
    // Directory at ROOT_A; slot 5 invalid but with frame and flag bits set (R6).
    for (int d = 0; d < 8; d++) begin
      logic [5:0] fl;
      fl = 6'((d * 13) & 'h3E);
      if (d == 5) mem[(int'(ROOT_A) >> 2) + d] = {6'd9, 6'h3E};
      else        mem[(int'(ROOT_A) >> 2) + d] = {6'(2 + d), fl | 6'h01};
      for (int t = 0; t < 8; t++) begin
        logic [5:0] tf;
        logic [5:0] fr;
        bit         pr;
        pr = ((d * 8 + t) % 7) != 3;
        fr = 6'((d * 8 + t * 5 + 11) % 54 + 10);
        tf = 6'(((d + t) * 19) & 'h3E);
        mem[(2 + d) * 16 + t] = {fr, tf | 6'(pr)};
      end
    end

    repeat (3) @(negedge clk);
    check(req_ready && !mem_rd_req && !rsp_valid, "R10", "reset outputs",
          PA_W'({req_ready, mem_rd_req, rsp_valid}), PA_W'(3'b100));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Full sweep with rotating latency (R1..R7, R9).
    for (int v = 0; v < (1 << VA_W); v++) begin
      lat = v % 4;
      walk(VA_W'(v), ROOT_A, 1'b0);
    end

    // Long latency.
    lat = 9;
    walk(12'h2C5, ROOT_A, 1'b0);
    walk(12'hA13, ROOT_A, 1'b0);

    // R8: root moves to an empty directory right after acceptance.
    lat = 2;
    walk(12'h1D7, ROOT_A, 1'b1);
    walk(12'hE41, ROOT_A, 1'b1);
    // Root pointing at the empty directory faults at level 0 (R8, R4).
    walk(12'h1D7, ROOT_E, 1'b0);
    // R2: low bits of the root pointer are ignored.
    walk(12'h3A9, ROOT_A | 12'h02C, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule